// File: doc/BRIEF.md
# Trap entry sequencer

This block carries out the control-state update a processor core makes when it takes a trap. The core has three execution levels: user, privileged and hyperprivileged. On a one-cycle trap request it receives the current values of these registers:

- trap level, global level, window pointer, address-space identifier and condition codes;
- the processor state word (PSW) and the hyperprivileged state word (HSW);
- the program counter and the next program counter.

From these it computes the new control state. It also pushes a snapshot of the old state into stacks that are indexed by trap level.

Two paths exist. The recovery path is taken when the HSW says the core is already in recovery state, or when the trap level is one below its maximum. Every other trap takes the normal path. On the normal path the new state depends on whether the handler runs hyperprivileged or privileged. Each bit of the PSW and HSW has its own rule on each path.

The results are registered. A single-cycle `done` pulse marks them one cycle after the request. The per-level stacks can be read back through a level-select read port.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is asserted, and after it is released, `done`, `red_taken`, `new_tl`, `new_gl`, `new_ps` and `new_hps` read zero. Every stack entry read through the read port is zero until the first trap.
- R2: A one-cycle `trap_valid` produces a one-cycle `done` on the next cycle. All `new_*` outputs change only on a cycle where `trap_valid` is high, and hold their values otherwise.
- R3: The recovery path is taken, and `red_taken` is set, when `cur_hps[5]` is 1 or `cur_tl` equals MAX_TL-1. Otherwise the normal path is taken.
- R4: `new_tl` equals `cur_tl`+1, saturating at MAX_TL. The stack entries written are those at level `new_tl`, and `rd_lvl` selects that level for reading.
- R5: The saved-state word packs the fields as follows:
  - bits 42:40 hold the global level (zero-extended);
  - bits 39:32 hold the condition codes;
  - bits 31:24 hold the address-space identifier;
  - bits 20:8 hold the full 13-bit PSW;
  - bits 4:0 hold the window pointer;
  - every other bit is zero.
- R6: The saved PC and next PC keep only their low 32 bits when `cur_ps[3]` (address mask) is 1. Otherwise they are saved at full width.
- R7: The saved HSW entry equals `cur_hps`, and the saved trap-type entry equals `trap_type`.
- R8: `new_gl` equals min(`cur_gl`+1, MAX_GL) on both paths.
- R9: On the normal path the PSW changes as follows:
  - bit 4 (FP enable) is set;
  - bits 3 (address mask) and 1 (interrupt enable) are cleared;
  - bits 7:6 (memory model), bit 8 (trap endian) and every bit without a rule keep their values.
- R10: On the normal path with `to_hyp`=1, the PSW and HSW change as follows:
  - PSW bit 9 (current endian) is cleared, and PSW bit 2 (priv) is kept;
  - in the HSW, bit 5 (recovery) is cleared, bit 2 (hpriv) is set and bit 10 (instruction break enable) is cleared;
  - HSW bit 0 (trap-level-zero watch) and the other HSW bits are kept.
- R11: On the normal path with `to_hyp`=0, PSW bit 2 is set and PSW bit 9 takes the value of PSW bit 8. The HSW is passed through unchanged.
- R12: On the recovery path, `to_hyp` has no effect, and the PSW and HSW change as follows:
  - the PSW becomes zero except that bit 2 is kept and bit 4 is set;
  - HSW bits 5 and 2 are set, HSW bits 10 and 0 are cleared, and the other HSW bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_type | input | 9 | Trap type code |
| to_hyp | input | 1 | Normal-path handler runs hyperprivileged |
| cur_tl | input | 3 | Current trap level |
| cur_gl | input | 2 | Current global level |
| cur_cwp | input | 5 | Current window pointer |
| cur_asi | input | 8 | Current address-space identifier |
| cur_ccr | input | 8 | Current condition codes |
| cur_ps | input | 13 | Current processor state word |
| cur_hps | input | 12 | Current hyperprivileged state word |
| cur_pc | input | 64 | Current program counter |
| cur_npc | input | 64 | Current next program counter |
| done | output | 1 | Update complete, one-cycle pulse |
| red_taken | output | 1 | Last trap used the recovery path |
| new_tl | output | 3 | Updated trap level |
| new_gl | output | 2 | Updated global level |
| new_ps | output | 13 | Updated processor state word |
| new_hps | output | 12 | Updated hyperprivileged state word |
| rd_lvl | input | 3 | Stack level to read (1..MAX_TL) |
| rd_tstate | output | 64 | Saved-state word at `rd_lvl` |
| rd_tpc | output | 64 | Saved PC at `rd_lvl` |
| rd_tnpc | output | 64 | Saved next PC at `rd_lvl` |
| rd_htstate | output | 12 | Saved HSW at `rd_lvl` |
| rd_tt | output | 9 | Saved trap type at `rd_lvl` |

## Verification
Every result of a trap is captured at the clock edge that samples `trap_valid`. The `new_*` outputs, `red_taken`, `done` and the stack contents are therefore all due one cycle after the request. The bench drives each request at a falling edge and reads the outputs at the next falling edge, where `done` must be high. It checks that `done` is low again one cycle later, while the outputs have held their values. The read port is combinational, so stack entries are compared a short delay after `rd_lvl` changes, with no further clock.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int MAX_TL = 6,
  parameter int MAX_GL = 3,
  parameter int CWP_W  = 5,
  parameter int TT_W   = 9,
  parameter int PS_W   = 13,
  parameter int HPS_W  = 12,
  parameter int VA_W   = 64,
  localparam int TL_W  = $clog2(MAX_TL + 1),
  localparam int GL_W  = $clog2(MAX_GL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_valid,
  input  logic [TT_W-1:0]  trap_type,
  input  logic             to_hyp,
  input  logic [TL_W-1:0]  cur_tl,
  input  logic [GL_W-1:0]  cur_gl,
  input  logic [CWP_W-1:0] cur_cwp,
  input  logic [7:0]       cur_asi,
  input  logic [7:0]       cur_ccr,
  input  logic [PS_W-1:0]  cur_ps,
  input  logic [HPS_W-1:0] cur_hps,
  input  logic [VA_W-1:0]  cur_pc,
  input  logic [VA_W-1:0]  cur_npc,
  output logic             done,
  output logic             red_taken,
  output logic [TL_W-1:0]  new_tl,
  output logic [GL_W-1:0]  new_gl,
  output logic [PS_W-1:0]  new_ps,
  output logic [HPS_W-1:0] new_hps,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic [63:0]      rd_tstate,
  output logic [VA_W-1:0]  rd_tpc,
  output logic [VA_W-1:0]  rd_tnpc,
  output logic [HPS_W-1:0] rd_htstate,
  output logic [TT_W-1:0]  rd_tt
);

  localparam int PS_IE   = 1;
  localparam int PS_PRIV = 2;
  localparam int PS_AM   = 3;
  localparam int PS_PEF  = 4;
  localparam int PS_TLE  = 8;
  localparam int PS_CLE  = 9;
  localparam int HS_TLZ  = 0;
  localparam int HS_HPRV = 2;
  localparam int HS_RED  = 5;
  localparam int HS_IBE  = 10;

  logic [63:0]      ts_q  [1:MAX_TL];
  logic [VA_W-1:0]  tpc_q [1:MAX_TL];
  logic [VA_W-1:0]  tnpc_q[1:MAX_TL];
  logic [HPS_W-1:0] hts_q [1:MAX_TL];
  logic [TT_W-1:0]  tt_q  [1:MAX_TL];

  logic             go_red;
  logic [TL_W:0]    tl_inc;
  logic [TL_W-1:0]  lvl;
  logic [GL_W:0]    gl_inc;
  logic [GL_W-1:0]  gl_nxt;
  logic [VA_W-1:0]  pc_mask;
  logic [63:0]      ts_word;
  logic [PS_W-1:0]  ps_nxt;
  logic [HPS_W-1:0] hps_nxt;
  logic             rd_ok;

  assign go_red  = cur_hps[HS_RED] | (cur_tl == TL_W'(MAX_TL - 1));
  assign tl_inc  = {1'b0, cur_tl} + 1'b1;
  assign lvl     = (tl_inc > (TL_W+1)'(MAX_TL)) ? TL_W'(MAX_TL) : tl_inc[TL_W-1:0];
  assign gl_inc  = {1'b0, cur_gl} + 1'b1;
  assign gl_nxt  = (gl_inc > (GL_W+1)'(MAX_GL)) ? GL_W'(MAX_GL) : gl_inc[GL_W-1:0];
  assign pc_mask = {{(VA_W-32){~cur_ps[PS_AM]}}, {32{1'b1}}};

  always_comb begin
    ts_word        = '0;
    ts_word[42:40] = 3'(cur_gl);
    ts_word[39:32] = cur_ccr;
    ts_word[31:24] = cur_asi;
    ts_word[20:8]  = 13'(cur_ps);
    ts_word[4:0]   = 5'(cur_cwp);
  end

  always_comb begin
    ps_nxt  = cur_ps;
    hps_nxt = cur_hps;
    if (go_red) begin
      ps_nxt          = '0;
      ps_nxt[PS_PRIV] = cur_ps[PS_PRIV];
      ps_nxt[PS_PEF]  = 1'b1;
      hps_nxt[HS_RED]  = 1'b1;
      hps_nxt[HS_HPRV] = 1'b1;
      hps_nxt[HS_IBE]  = 1'b0;
      hps_nxt[HS_TLZ]  = 1'b0;
    end else begin
      ps_nxt[PS_PEF] = 1'b1;
      ps_nxt[PS_AM]  = 1'b0;
      ps_nxt[PS_IE]  = 1'b0;
      if (to_hyp) begin
        ps_nxt[PS_CLE]   = 1'b0;
        hps_nxt[HS_RED]  = 1'b0;
        hps_nxt[HS_HPRV] = 1'b1;
        hps_nxt[HS_IBE]  = 1'b0;
      end else begin
        ps_nxt[PS_PRIV] = 1'b1;
        ps_nxt[PS_CLE]  = cur_ps[PS_TLE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      red_taken <= 1'b0;
      new_tl    <= '0;
      new_gl    <= '0;
      new_ps    <= '0;
      new_hps   <= '0;
    end else begin
      done <= trap_valid;
      if (trap_valid) begin
        red_taken <= go_red;
        new_tl    <= lvl;
        new_gl    <= gl_nxt;
        new_ps    <= ps_nxt;
        new_hps   <= hps_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= MAX_TL; i++) begin
        ts_q[i]   <= '0;
        tpc_q[i]  <= '0;
        tnpc_q[i] <= '0;
        hts_q[i]  <= '0;
        tt_q[i]   <= '0;
      end
    end else if (trap_valid) begin
      ts_q[lvl]   <= ts_word;
      tpc_q[lvl]  <= cur_pc & pc_mask;
      tnpc_q[lvl] <= cur_npc & pc_mask;
      hts_q[lvl]  <= cur_hps;
      tt_q[lvl]   <= trap_type;
    end
  end

  assign rd_ok      = (rd_lvl != '0) && (rd_lvl <= TL_W'(MAX_TL));
  assign rd_tstate  = rd_ok ? ts_q[rd_lvl]   : '0;
  assign rd_tpc     = rd_ok ? tpc_q[rd_lvl]  : '0;
  assign rd_tnpc    = rd_ok ? tnpc_q[rd_lvl] : '0;
  assign rd_htstate = rd_ok ? hts_q[rd_lvl]  : '0;
  assign rd_tt      = rd_ok ? tt_q[rd_lvl]   : '0;

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int MAX_TL = 6,
  parameter int TL_W   = 3,
  parameter int GL_W   = 2,
  parameter int PS_W   = 13,
  parameter int HPS_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trap_valid,
  input logic             to_hyp,
  input logic [TL_W-1:0]  cur_tl,
  input logic [PS_W-1:0]  cur_ps,
  input logic [HPS_W-1:0] cur_hps,
  input logic             done,
  input logic             red_taken,
  input logic [TL_W-1:0]  new_tl,
  input logic [PS_W-1:0]  new_ps,
  input logic [HPS_W-1:0] new_hps
);

  logic red_cond;
  assign red_cond = cur_hps[5] || (cur_tl == TL_W'(MAX_TL - 1));

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> done);  // R2
  AST_DONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !done);  // R2
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> $stable(new_ps) && $stable(new_hps) && $stable(new_tl));  // R2
  AST_RED_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && red_cond |=> red_taken);  // R3
  AST_TL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && (cur_tl < TL_W'(MAX_TL)) |=> new_tl == $past(cur_tl) + 1'b1);  // R4
  AST_PEF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_ps[4]);  // R9
  AST_PRIV_HPS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid && !red_cond && !to_hyp |=> new_hps == $past(cur_hps));  // R11
  AST_RED_HPS: assert property (@(posedge clk) disable iff (!rst_n)
    done && red_taken |-> new_hps[5] && new_hps[2] && !new_hps[10] && !new_hps[0]);  // R12

endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .MAX_TL(MAX_TL), .TL_W(TL_W), .GL_W(GL_W), .PS_W(PS_W), .HPS_W(HPS_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .to_hyp(to_hyp),
  .cur_tl(cur_tl), .cur_ps(cur_ps), .cur_hps(cur_hps), .done(done),
  .red_taken(red_taken), .new_tl(new_tl), .new_ps(new_ps), .new_hps(new_hps)
);

// File: tb/trap_entry_seq_tb.sv
`timescale 1ns/1ps
module trap_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_valid = 1'b0;
  logic [8:0]  trap_type = '0;
  logic        to_hyp = 1'b0;
  logic [2:0]  cur_tl = '0;
  logic [1:0]  cur_gl = '0;
  logic [4:0]  cur_cwp = '0;
  logic [7:0]  cur_asi = '0;
  logic [7:0]  cur_ccr = '0;
  logic [12:0] cur_ps = '0;
  logic [11:0] cur_hps = '0;
  logic [63:0] cur_pc = '0;
  logic [63:0] cur_npc = '0;
  logic        done, red_taken;
  logic [2:0]  new_tl;
  logic [1:0]  new_gl;
  logic [12:0] new_ps;
  logic [11:0] new_hps;
  logic [2:0]  rd_lvl = 3'd1;
  logic [63:0] rd_tstate, rd_tpc, rd_tnpc;
  logic [11:0] rd_htstate;
  logic [8:0]  rd_tt;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  trap_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_type(trap_type),
    .to_hyp(to_hyp), .cur_tl(cur_tl), .cur_gl(cur_gl), .cur_cwp(cur_cwp),
    .cur_asi(cur_asi), .cur_ccr(cur_ccr), .cur_ps(cur_ps), .cur_hps(cur_hps),
    .cur_pc(cur_pc), .cur_npc(cur_npc), .done(done), .red_taken(red_taken),
    .new_tl(new_tl), .new_gl(new_gl), .new_ps(new_ps), .new_hps(new_hps),
    .rd_lvl(rd_lvl), .rd_tstate(rd_tstate), .rd_tpc(rd_tpc), .rd_tnpc(rd_tnpc),
    .rd_htstate(rd_htstate), .rd_tt(rd_tt)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_ps(input logic [12:0] p, input logic hyp, input logic red);
    logic [12:0] r;
    if (red) begin
      r = '0; r[2] = p[2]; r[4] = 1'b1;
    end else begin
      r = p; r[4] = 1'b1; r[3] = 1'b0; r[1] = 1'b0;
      if (hyp) r[9] = 1'b0;
      else begin r[2] = 1'b1; r[9] = p[8]; end
    end
    return r;
  endfunction

  function automatic logic [11:0] exp_hps(input logic [11:0] h, input logic hyp, input logic red);
    logic [11:0] r = h;
    if (red) begin r[5] = 1'b1; r[2] = 1'b1; r[10] = 1'b0; r[0] = 1'b0; end
    else if (hyp) begin r[5] = 1'b0; r[2] = 1'b1; r[10] = 1'b0; end
    return r;
  endfunction

  task automatic do_trap(input logic [8:0] tt, input logic hyp, input logic [2:0] tl,
                         input logic [1:0] gl, input logic [4:0] cwp, input logic [7:0] asi,
                         input logic [7:0] ccr, input logic [12:0] ps, input logic [11:0] hps,
                         input logic [63:0] pc, input logic [63:0] npc);
    logic red;
    logic [2:0] lvl;
    logic [1:0] gexp;
    logic [63:0] ts, msk;
    logic [12:0] ps_e;
    logic [11:0] hps_e;
    @(negedge clk);
    trap_type = tt; to_hyp = hyp; cur_tl = tl; cur_gl = gl; cur_cwp = cwp;
    cur_asi = asi; cur_ccr = ccr; cur_ps = ps; cur_hps = hps; cur_pc = pc; cur_npc = npc;
    trap_valid = 1'b1;
    red  = hps[5] || (tl == 3'd5);
    lvl  = (tl >= 3'd6) ? 3'd6 : tl + 3'd1;
    gexp = (gl == 2'd3) ? 2'd3 : gl + 2'd1;
    ts   = ({61'd0, 1'b0, gl} << 40) | ({56'd0, ccr} << 32) | ({56'd0, asi} << 24)
         | ({51'd0, ps} << 8) | {59'd0, cwp};
    msk  = ps[3] ? 64'h0000_0000_FFFF_FFFF : '1;
    ps_e  = exp_ps(ps, hyp, red);
    hps_e = exp_hps(hps, hyp, red);
    @(negedge clk);
    trap_valid = 1'b0;
    chk("R2", "done", done, 1);
    chk("R3", "red_taken", red_taken, red);
    chk("R4", "new_tl", new_tl, lvl);
    chk("R8", "new_gl", new_gl, gexp);
    if (red) begin
      chk("R12", "new_ps", new_ps, ps_e);
      chk("R12", "new_hps", new_hps, hps_e);
    end else if (hyp) begin
      chk("R10", "new_ps", new_ps, ps_e);
      chk("R10", "new_hps", new_hps, hps_e);
    end else begin
      chk("R11", "new_ps", new_ps, ps_e);
      chk("R11", "new_hps", new_hps, hps_e);
    end
    chk("R9", "new_ps pef/am/ie", {61'd0, new_ps[4], new_ps[3], new_ps[1]}, {61'd0, 1'b1, 1'b0, 1'b0});
    rd_lvl = lvl;
    #1;
    chk("R5", "tstate", rd_tstate, ts);
    chk("R6", "tpc", rd_tpc, pc & msk);
    chk("R6", "tnpc", rd_tnpc, npc & msk);
    chk("R7", "htstate", rd_htstate, hps);
    chk("R7", "tt", rd_tt, tt);
    cur_ps = ~ps; cur_hps = ~hps; cur_tl = 3'd0;
    @(negedge clk);
    chk("R2", "done low", done, 0);
    chk("R2", "new_ps held", new_ps, ps_e);
    chk("R2", "new_hps held", new_hps, hps_e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "done", done, 0);
    chk("R1", "red_taken", red_taken, 0);
    chk("R1", "new_tl", new_tl, 0);
    chk("R1", "new_gl", new_gl, 0);
    chk("R1", "new_ps", new_ps, 0);
    chk("R1", "new_hps", new_hps, 0);
    for (int l = 1; l <= 6; l++) begin
      rd_lvl = 3'(l);
      #1;
      chk("R1", "tstate", rd_tstate, 0);
      chk("R1", "tpc", rd_tpc, 0);
    end
  endtask

  task automatic t_normal_priv;
    // tle=1, mm=10, ie=1: cle takes tle
    do_trap(9'h024, 1'b0, 3'd0, 2'd0, 5'd3, 8'h80, 8'h5A, 13'b1_0001_1000_0010, 12'h800,
            64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF4);
    // tle=0, cle=1, am=1: cle cleared, PCs masked
    do_trap(9'h041, 1'b0, 3'd1, 2'd1, 5'd17, 8'h04, 8'hC3, 13'b0_0010_0000_1000, 12'h801,
            64'hFFFF_0000_0000_1000, 64'hFFFF_0000_0000_1004);
  endtask

  task automatic t_normal_hyp;
    // tlz and ibe set, priv 0, cle 1, pid bits set
    do_trap(9'h07F, 1'b1, 3'd2, 2'd2, 5'd31, 8'h14, 8'h11, 13'b1_1111_0001_1011, 12'hC01,
            64'hDEAD_BEEF_0000_0040, 64'hDEAD_BEEF_0000_0044);
  endtask

  task automatic t_red_by_flag;
    // HSW recovery bit set; to_hyp=0 must have no effect
    do_trap(9'h100, 1'b0, 3'd2, 2'd1, 5'd2, 8'hFF, 8'hFF, 13'h1FFF, 12'hC25,
            64'h0000_0001_0000_0000, 64'h0000_0001_0000_0004);
    do_trap(9'h101, 1'b1, 3'd0, 2'd0, 5'd7, 8'h01, 8'h02, 13'h0B1A, 12'h821,
            64'h0000_0000_0000_2000, 64'h0000_0000_0000_2004);
  endtask

  task automatic t_red_by_level;
    // tl = MAX_TL-1 and gl saturated
    do_trap(9'h0AA, 1'b1, 3'd5, 2'd3, 5'd9, 8'h2C, 8'h77, 13'h0004, 12'h401,
            64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_BBBB_CCCC_DDE1);
  endtask

  task automatic t_tl_saturate;
    // tl already at MAX_TL: normal path, level stays at MAX_TL
    do_trap(9'h033, 1'b0, 3'd6, 2'd2, 5'd12, 8'h88, 8'h99, 13'h0140, 12'h800,
            64'h0000_0000_0000_3000, 64'h0000_0000_0000_3004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_normal_priv();
    t_normal_hyp();
    t_red_by_flag();
    t_red_by_level();
    t_tl_saturate();
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule